// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block produces a periodic interrupt from the core clock. A programmable prescaler divides the clock down into ticks. A 16-bit live counter moves down by one on each tick. When a tick arrives while the counter already holds zero, the counter is refilled from a separate period register and a one-cycle interrupt pulse is raised. Software reaches the three registers through a flat word port: address, write data, write strobe and a combinational read-back. A single enable input starts and freezes the timer.

The prescale register holds n−1, so the counter steps once every n enabled cycles, with n from 1 to 256. The counter, the prescale value and the period value are separate registers. Software can therefore change the reload value without disturbing the count in flight, and it can also overwrite the live count directly.

Top module: `ivtmr_top`

## Requirements
- R1: After a synchronous reset the count, prescale and period registers all read 0, the prescaler phase is 0 and `irq` is low.
- R2: Register map on `addr`: 0 is the live count (16 bits), 1 is the prescale value (bits 7:0, upper read bits are 0 and upper write bits are dropped), 2 is the period (16 bits), and 3 reads as 0 with writes having no effect on any register.
- R3: With prescale value s, a tick occurs once every s+1 enabled cycles, counted from the last tick or the last prescaler restart.
- R4: On a tick with a nonzero count, the count decreases by exactly one.
- R5: On a tick with the count at zero, the count is reloaded from the period register, and `irq` is high for the one cycle following that clock edge.
- R6: A period of 0 gives an interrupt on every tick; a prescale of 0 gives a tick on every enabled cycle.
- R7: A write to address 0 sets the count on the next edge, restarts the prescaler phase at 0, and overrides any tick in that cycle (no decrement, reload or interrupt).
- R8: While `en` is low the count and the prescaler phase hold and `irq` stays low; register writes still take effect.
- R9: A prescale write keeps the current phase; if the phase already meets or exceeds the new value, the next enabled cycle is a tick.
- R10: A period write does not change the live count; the new value is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Timer run enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read of the selected register |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The countdown is tried with a mid-sized prescale and period, where ticks separate from cycles and reloads separate from decrements. It is also tried with a period of zero, which separates "interrupt on zero" from "interrupt after decrement to zero". A prescale of zero with a period of zero drives the interrupt high on consecutive cycles. The largest prescale value exposes off-by-one errors in the divider. Writes to the count and prescale registers land at chosen prescaler phases, and the enable is toggled mid-count, to tell apart restart, phase keeping and freezing. A cycle-accurate behavioural model compares the interrupt and the read-back every cycle.

// File: rtl/ivtmr_pkg.sv
package ivtmr_pkg;

    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_COUNT  = 2'd0,
        SEL_SCALE  = 2'd1,
        SEL_PERIOD = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic count;
        logic scale;
        logic period;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic we, input logic [ADDR_W-1:0] a);
        wr_strobe_t s;
        s = '0;
        if (we) begin
            case (reg_sel_e'(a))
                SEL_COUNT:  s.count  = 1'b1;
                SEL_SCALE:  s.scale  = 1'b1;
                SEL_PERIOD: s.period = 1'b1;
                default:    s        = '0;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/ivtmr_regs.sv
module ivtmr_regs
    import ivtmr_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [CNT_W-1:0]   cnt_val,
    output wr_strobe_t         strb,
    output logic [SCALE_W-1:0] scale_q,
    output logic [CNT_W-1:0]   period_q,
    output logic [CNT_W-1:0]   rd_data
);

    assign strb = decode_write(wr_en, addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            scale_q  <= '0;
            period_q <= '0;
        end else begin
            if (strb.scale)  scale_q  <= wr_data[SCALE_W-1:0];
            if (strb.period) period_q <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(addr))
            SEL_COUNT:  rd_data = cnt_val;
            SEL_SCALE:  rd_data[SCALE_W-1:0] = scale_q;
            SEL_PERIOD: rd_data = period_q;
            default:    rd_data = '0;
        endcase
    end

    // R10: period only changes when written
    p_period_kept_r10: assert property (@(posedge clk) disable iff (rst)
        !strb.period |=> $stable(period_q));

    // R2: spare address never disturbs stored values
    p_spare_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 2'd3) |=> ($stable(scale_q) && $stable(period_q)));

endmodule

// File: rtl/ivtmr_prescaler.sv
module ivtmr_prescaler #(
    parameter int unsigned SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               restart,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick
);

    logic [SCALE_W-1:0] phase;
    logic               wrap;

    assign wrap = (phase >= scale);
    assign tick = en && !restart && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (restart) begin
            phase <= '0;
        end else if (en) begin
            phase <= wrap ? '0 : phase + 1'b1;
        end
    end

    // R7: restart zeroes the phase
    p_phase_restart_r7: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase == '0));

    // R8: disabled prescaler holds
    p_phase_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!en && !restart) |=> $stable(phase));

    // R3: phase never runs past the limit without a tick
    p_phase_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !restart && phase < scale) |=> (phase == $past(phase) + 1'b1));

endmodule

// File: rtl/ivtmr_counter.sv
module ivtmr_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);

    logic at_zero;
    logic expire;

    assign at_zero = (cnt == '0);
    assign expire  = tick && !load && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= expire;
            if (load) begin
                cnt <= load_val;
            end else if (tick) begin
                cnt <= at_zero ? period : cnt - 1'b1;
            end
        end
    end

    // R4: nonzero count steps down by one per tick
    p_decrement_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1) && !irq);

    // R5: expiry reloads from the period and pulses the interrupt
    p_reload_irq_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt == '0) |=> (irq && cnt == $past(period)));

    // R7: software load wins and suppresses the interrupt
    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val) && !irq));

    // R8: disabled timer holds and stays quiet
    p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> ($stable(cnt) && !irq));

endmodule

// File: rtl/ivtmr_top.sv
module ivtmr_top
    import ivtmr_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned SCALE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);

    wr_strobe_t         strb;
    logic [SCALE_W-1:0] scale_q;
    logic [CNT_W-1:0]   period_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               tick;

    ivtmr_regs #(.CNT_W(CNT_W), .SCALE_W(SCALE_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_data  (wr_data),
        .cnt_val  (cnt_q),
        .strb     (strb),
        .scale_q  (scale_q),
        .period_q (period_q),
        .rd_data  (rd_data)
    );

    ivtmr_prescaler #(.SCALE_W(SCALE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .restart (strb.count),
        .scale   (scale_q),
        .tick    (tick)
    );

    ivtmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick     (tick),
        .load     (strb.count),
        .load_val (wr_data),
        .period   (period_q),
        .cnt      (cnt_q),
        .irq      (irq)
    );

    // R1: quiet interrupt line right after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!irq && cnt_q == '0));

endmodule

// File: tb/ivtmr_top_test.sv
module ivtmr_top_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic        wr_en;
    logic [1:0]  addr;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // behavioural reference state
    int m_cnt, m_ps, m_scale, m_period;
    bit m_irq;

    always #5 clk = ~clk;

    ivtmr_top uut (
        .clk(clk), .rst(rst), .en(en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_read(input logic [1:0] a);
        case (a)
            2'd0: return m_cnt;
            2'd1: return m_scale;
            2'd2: return m_period;
            default: return 0;
        endcase
    endfunction

    // one clock: drive, advance model, compare both outputs
    task automatic step(input bit we, input logic [1:0] a, input logic [15:0] d,
                        input bit e, input string tag);
        bit cw, tk;
        @(negedge clk);
        wr_en = we; addr = a; wr_data = d; en = e;
        @(posedge clk);
        cw = we && (a == 2'd0);
        tk = e && !cw && (m_ps >= m_scale);
        m_irq = tk && (m_cnt == 0);
        if (cw) m_ps = 0;
        else if (e) m_ps = (m_ps >= m_scale) ? 0 : m_ps + 1;
        if (cw) m_cnt = d;
        else if (tk) m_cnt = (m_cnt == 0) ? m_period : m_cnt - 1;
        if (we && a == 2'd1) m_scale = d[7:0];
        if (we && a == 2'd2) m_period = d;
        #2;
        check(irq == m_irq, {tag, " irq"}, irq, m_irq);
        check(rd_data == model_read(a), {tag, " read"}, rd_data, model_read(a));
    endtask

    task automatic run(input int n, input logic [1:0] a, input bit e, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, a, 16'h0, e, tag);
    endtask

    task automatic count_irqs(input int n, input string tag, input int exp);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            step(1'b0, 2'd0, 16'h0, 1'b1, tag);
            if (irq) seen++;
        end
        check(seen == exp, {tag, " irq count"}, seen, exp);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en = 1'b0; wr_en = 1'b0; addr = 2'd0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cnt = 0; m_ps = 0; m_scale = 0; m_period = 0; m_irq = 0;

        // R1: reset values on every address
        #1;
        check(irq == 1'b0, "R1 irq after reset", irq, 0);
        check(rd_data == 16'h0, "R1 count after reset", rd_data, 0);
        step(1'b0, 2'd1, 16'h0, 1'b0, "R1");
        step(1'b0, 2'd2, 16'h0, 1'b0, "R1");

        // R2: register map, truncation, spare address
        step(1'b1, 2'd1, 16'hABCD, 1'b0, "R2");
        check(rd_data == 16'h00CD, "R2 prescale width", rd_data, 16'h00CD);
        step(1'b1, 2'd2, 16'h1234, 1'b0, "R2");
        step(1'b1, 2'd0, 16'h0042, 1'b0, "R2");
        step(1'b1, 2'd3, 16'hFFFF, 1'b0, "R2");
        check(rd_data == 16'h0, "R2 spare reads zero", rd_data, 0);
        step(1'b0, 2'd0, 16'h0, 1'b0, "R2");
        step(1'b0, 2'd1, 16'h0, 1'b0, "R2");
        step(1'b0, 2'd2, 16'h0, 1'b0, "R2");

        // R3 R4 R5: scale 2, period 3, count 5
        step(1'b1, 2'd1, 16'd2, 1'b0, "R3");
        step(1'b1, 2'd2, 16'd3, 1'b0, "R5");
        step(1'b1, 2'd0, 16'd5, 1'b0, "R4");
        // first expiry after 6 ticks (18 cycles), then every 4 ticks (12 cycles)
        count_irqs(18, "R3", 1);
        count_irqs(24, "R5", 2);

        // R6: period 0 and scale 0 -> irq every cycle
        step(1'b1, 2'd1, 16'd0, 1'b0, "R6");
        step(1'b1, 2'd2, 16'd0, 1'b0, "R6");
        step(1'b1, 2'd0, 16'd0, 1'b0, "R6");
        count_irqs(10, "R6", 10);
        // period 0 with scale 3 -> irq every 4 cycles
        step(1'b1, 2'd1, 16'd3, 1'b0, "R6");
        step(1'b1, 2'd0, 16'd0, 1'b0, "R6");
        count_irqs(16, "R6 scaled", 4);

        // R7: count write mid-run restarts phase and wins over a tick
        step(1'b1, 2'd2, 16'd7, 1'b1, "R7");
        step(1'b1, 2'd0, 16'd2, 1'b1, "R7");
        run(2, 2'd0, 1'b1, "R7");
        step(1'b1, 2'd0, 16'd9, 1'b1, "R7");
        check(rd_data == 16'd9, "R7 count write immediate", rd_data, 9);
        step(1'b1, 2'd0, 16'd0, 1'b1, "R7");
        run(8, 2'd0, 1'b1, "R7");

        // R8: freeze with enable low, writes still land
        run(3, 2'd0, 1'b1, "R8");
        run(6, 2'd0, 1'b0, "R8");
        step(1'b1, 2'd2, 16'd5, 1'b0, "R8");
        check(rd_data == 16'd5, "R8 write while off", rd_data, 5);
        run(4, 2'd0, 1'b0, "R8");
        run(12, 2'd0, 1'b1, "R8");

        // R9: lower the prescale while the phase is high
        step(1'b1, 2'd1, 16'd7, 1'b1, "R9");
        step(1'b1, 2'd0, 16'd4, 1'b1, "R9");
        run(5, 2'd0, 1'b1, "R9");
        step(1'b1, 2'd1, 16'd1, 1'b1, "R9");
        run(10, 2'd0, 1'b1, "R9");

        // R10: period write leaves the live count alone
        step(1'b1, 2'd0, 16'd6, 1'b1, "R10");
        step(1'b1, 2'd2, 16'd2, 1'b1, "R10");
        step(1'b0, 2'd0, 16'd0, 1'b1, "R10");
        check(rd_data == 16'd6 || rd_data == 16'd5, "R10 count kept", rd_data, 6);
        run(30, 2'd0, 1'b1, "R10");

        // R3: largest divider, period 1
        step(1'b1, 2'd1, 16'd255, 1'b0, "R3");
        step(1'b1, 2'd2, 16'd1, 1'b0, "R3");
        step(1'b1, 2'd0, 16'd0, 1'b0, "R3");
        count_irqs(256 * 4, "R3 max scale", 2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule